// File: doc/BRIEF.md
# Escape Sequence Detector

This block watches the receive side of a serial port for an escape sequence: a run of identical, configurable characters, with quiet periods on the line before and after the run. It sees every received byte through a one-cycle valid strobe, and it sees a one-cycle tick once per bit period from the baud generator. Every timing value is counted in these ticks.

The line must be quiet for a configured number of ticks before the first character. Each later character must follow the previous byte within a configured gap. After the last character of the run, the line must stay quiet for a configured number of ticks. When all of this holds, a sticky raw interrupt bit is set, and it stays set until it is cleared with a write-one strobe. Any deviation from the expected sequence makes the block go back to searching for a new first character.

Top module: `esc_seq_detect`

## Requirements
- R1: After reset, `det_o` is 0. The quiet-tick count starts at zero at reset and restarts at zero on every received byte. A tick in the same cycle as a byte is not counted.
- R2: A byte equal to `cfg_char_i` starts a sequence only when at least `cfg_pre_idle_i` ticks have elapsed since the previous byte, or since reset if no byte has arrived yet.
- R3: Each further matching byte is accepted only when at most `cfg_gap_i` ticks have elapsed since the previous byte. If the count passes `cfg_gap_i`, the search restarts.
- R4: A byte that does not match while a sequence is in progress restarts the search. That byte does not start a new sequence.
- R5: Once `cfg_count_i` matching bytes have been accepted, `det_o` rises on the clock edge after the first cycle in which at least `cfg_post_idle_i` ticks have elapsed since the last byte. Any byte during this wait cancels the detection, including an extra matching byte.
- R6: `det_o` stays set until `clr_i` is high. If a detection and `clr_i` fall in the same cycle, the detection wins.
- R7: When `cfg_count_i` is 1, a single guarded character is enough for a detection. When `cfg_count_i` is 0, the block never detects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe, one cycle per byte |
| rx_byte_i | input | 8 | Received byte |
| bit_tick_i | input | 1 | One pulse per bit period |
| cfg_char_i | input | 8 | Character that makes up the escape sequence |
| cfg_count_i | input | 8 | Number of characters in the run |
| cfg_pre_idle_i | input | 16 | Minimum quiet ticks before the first character |
| cfg_gap_i | input | 16 | Maximum ticks between consecutive characters |
| cfg_post_idle_i | input | 16 | Quiet ticks required after the last character |
| clr_i | input | 1 | Write-one clear of the raw bit |
| det_o | output | 1 | Sticky raw detection interrupt |

## Verification
A wrong quiet-tick count or a wrong sequence state shows up only on `det_o`. It appears either as a detection that fires one or more bit periods too early, or as a detection that never fires. The error becomes visible once the post-idle window ends, which is at most `cfg_post_idle_i` ticks after the final character. For this reason the bench places runs exactly on each timing boundary and one tick beyond it, and it samples `det_o` both one cycle before and at the edge where the bit should rise. A flag that loses its sticky behaviour, or drops a detection that arrives together with a clear, is exposed by the very next sample.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_POST    = 2'd2
  } esc_state_e;
endpackage

// File: rtl/esc_idle_timer.sv
module esc_idle_timer #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              bit_tick_i,
  output logic [TIME_W-1:0] idle_cnt_o
);
  localparam logic [TIME_W-1:0] CntMax = {TIME_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 idle_cnt_o <= '0;
    else if (rx_valid_i)                         idle_cnt_o <= '0;
    else if (bit_tick_i && idle_cnt_o != CntMax) idle_cnt_o <= idle_cnt_o + 1'b1;
  end

  p_restart_on_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> idle_cnt_o == '0);
  p_hold_without_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i && !bit_tick_i) |=> $stable(idle_cnt_o));
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_seq_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_byte_i,
  input  logic [TIME_W-1:0] idle_cnt_i,
  input  logic [CHAR_W-1:0] cfg_char_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [TIME_W-1:0] cfg_pre_idle_i,
  input  logic [TIME_W-1:0] cfg_gap_i,
  input  logic [TIME_W-1:0] cfg_post_idle_i,
  output logic              det_pulse_o
);
  esc_state_e       state_q, state_d;
  logic [CNT_W-1:0] hits_q, hits_d;
  logic             is_match;
  logic [CNT_W:0]   hits_next;

  assign is_match  = rx_valid_i && (rx_byte_i == cfg_char_i);
  assign hits_next = {1'b0, hits_q} + 1'b1;

  always_comb begin
    state_d     = state_q;
    hits_d      = hits_q;
    det_pulse_o = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (is_match && idle_cnt_i >= cfg_pre_idle_i && cfg_count_i != '0) begin
          hits_d  = CNT_W'(1);
          state_d = (cfg_count_i == CNT_W'(1)) ? ST_POST : ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (rx_valid_i) begin
          if (is_match && idle_cnt_i <= cfg_gap_i) begin
            hits_d  = hits_next[CNT_W-1:0];
            state_d = (hits_next == {1'b0, cfg_count_i}) ? ST_POST : ST_COLLECT;
          end else begin
            state_d = ST_HUNT;
          end
        end else if (idle_cnt_i > cfg_gap_i) begin
          state_d = ST_HUNT;
        end
      end
      ST_POST: begin
        if (rx_valid_i) begin
          state_d = ST_HUNT;
        end else if (idle_cnt_i >= cfg_post_idle_i) begin
          det_pulse_o = 1'b1;
          state_d     = ST_HUNT;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      hits_q  <= '0;
    end else begin
      state_q <= state_d;
      hits_q  <= hits_d;
    end
  end

  p_start_guarded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && state_d != ST_HUNT) |-> (idle_cnt_i >= cfg_pre_idle_i));
  p_post_entered_on_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_POST) |-> $past(rx_valid_i));
  p_hunt_after_det_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_pulse_o |=> state_q == ST_HUNT);
  p_zero_count_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && cfg_count_i == '0) |=> state_q == ST_HUNT);
endmodule

// File: rtl/esc_irq_flag.sv
module esc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_byte_i,
  input  logic              bit_tick_i,
  input  logic [CHAR_W-1:0] cfg_char_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [TIME_W-1:0] cfg_pre_idle_i,
  input  logic [TIME_W-1:0] cfg_gap_i,
  input  logic [TIME_W-1:0] cfg_post_idle_i,
  input  logic              clr_i,
  output logic              det_o
);
  logic [TIME_W-1:0] idle_cnt;
  logic              det_pulse;

  esc_idle_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .bit_tick_i (bit_tick_i),
    .idle_cnt_o (idle_cnt)
  );

  esc_seq_fsm #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rx_valid_i      (rx_valid_i),
    .rx_byte_i       (rx_byte_i),
    .idle_cnt_i      (idle_cnt),
    .cfg_char_i      (cfg_char_i),
    .cfg_count_i     (cfg_count_i),
    .cfg_pre_idle_i  (cfg_pre_idle_i),
    .cfg_gap_i       (cfg_gap_i),
    .cfg_post_idle_i (cfg_post_idle_i),
    .det_pulse_o     (det_pulse)
  );

  esc_irq_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (det_pulse),
    .clr_i  (clr_i),
    .flag_o (det_o)
  );

  p_rise_needs_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(!rx_valid_i));
endmodule

// File: tb/esc_seq_detect_bench.sv
module esc_seq_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tick = 1'b0;
  logic [7:0]  cfg_char = 8'h2B;
  logic [7:0]  cfg_count = 8'd3;
  logic [15:0] cfg_pre = 16'd4;
  logic [15:0] cfg_gap = 16'd2;
  logic [15:0] cfg_post = 16'd4;
  logic        clr = 1'b0;
  logic        det;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  esc_seq_detect u_esc_seq_detect (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .bit_tick_i(tick), .cfg_char_i(cfg_char), .cfg_count_i(cfg_count),
    .cfg_pre_idle_i(cfg_pre), .cfg_gap_i(cfg_gap), .cfg_post_idle_i(cfg_post),
    .clr_i(clr), .det_o(det)
  );

  // monitor: compares queued expectations at the next falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (det !== e.exp) begin
        fails++;
        $display("FAIL %s: det_o actual %0b expected %0b", e.tag, det, e.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input bit v, input logic [7:0] b, input bit t, input bit c);
    rx_valid = v; rx_byte = b; tick = t; clr = c;
    @(posedge clk); #1;
    rx_valid = 1'b0; tick = 1'b0; clr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b); cyc(1'b1, b, 1'b0, 1'b0); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0); endtask
  task automatic clear(); cyc(1'b0, 8'h00, 1'b0, 1'b1); endtask
  task automatic expect_det(input bit e, input string tag);
    exp_t x; x.exp = e; x.tag = tag; exp_q.push_back(x);
    idle(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_det(1'b0, "R1 reset value");

    // happy path, post boundary
    ticks(4); send(8'h2B); send(8'h2B); send(8'h2B);
    ticks(3);
    expect_det(1'b0, "R5 one tick short of post idle");
    ticks(1);
    expect_det(1'b0, "R5 not yet at edge");
    expect_det(1'b1, "R5 detection after post idle");
    send(8'h41);
    expect_det(1'b1, "R6 sticky across traffic");
    clear();
    expect_det(1'b0, "R6 cleared");

    // pre-idle too short
    send(8'h41); ticks(3); send(8'h2B); send(8'h2B); send(8'h2B); ticks(6);
    expect_det(1'b0, "R2 short pre idle rejected");

    // gap exceeded
    send(8'h41); ticks(4); send(8'h2B); ticks(3); send(8'h2B); send(8'h2B); ticks(6);
    expect_det(1'b0, "R3 gap exceeded restarts");

    // gap exactly at limit
    ticks(4); send(8'h2B); ticks(2); send(8'h2B); ticks(2); send(8'h2B); ticks(4); idle(1);
    expect_det(1'b1, "R3 gap at limit accepted");
    clear();

    // non-matching in middle
    ticks(4); send(8'h2B); send(8'h2C); send(8'h2B); send(8'h2B); ticks(6);
    expect_det(1'b0, "R4 mismatch restarts");

    // extra matching byte
    ticks(4); send(8'h2B); send(8'h2B); send(8'h2B); send(8'h2B); ticks(6);
    expect_det(1'b0, "R5 extra char cancels");

    // byte during post wait
    ticks(4); send(8'h2B); send(8'h2B); send(8'h2B); ticks(2); send(8'h41); ticks(6);
    expect_det(1'b0, "R5 byte during post cancels");

    // set wins over clear in same cycle
    ticks(4); send(8'h2B); send(8'h2B); send(8'h2B); ticks(4);
    clear();
    expect_det(1'b1, "R6 set beats clear");
    clear();
    expect_det(1'b0, "R6 clear after set");

    // count of one
    cfg_count = 8'd1;
    ticks(4); send(8'h2B); ticks(4); idle(1);
    expect_det(1'b1, "R7 single character");
    clear();

    // count of zero
    cfg_count = 8'd0;
    ticks(4); send(8'h2B); ticks(6);
    expect_det(1'b0, "R7 zero count never detects");

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule